// File: doc/BRIEF.md
# Stereo Digital Volume and Mute Stage

This block scales a stream of signed 16-bit audio samples in the playback path. Each sample arrives with a one-cycle valid strobe and a flag that says whether it belongs to the left or the right channel. The block combines a per-channel attenuation with a master attenuation, both set in whole decibels. It turns the total into a gain factor from a small lookup and multiplies the sample by it. The result leaves the block a fixed two cycles later with its own strobe.

A master mute silences both channels without disturbing the strobe timing. In mono mode every sample is scaled with the left-channel setting. Level and mute inputs are captured only at the start of a frame, which is the strobe of a left sample, or of any sample in mono mode. The two halves of a stereo pair therefore always share one set of settings. The gain law steps 6 dB per octave of shift from six base factors. This keeps the table cheap and exact to reproduce.

Top module: `stereo_level_ctl`

## Requirements
- R1: After reset, out_vld and out_data are 0, and the captured level and mute settings are all zero, meaning 0 dB and unmuted.
- R2: out_vld is high exactly two rising edges after the edge that samples in_vld high, and nowhere else. out_right carries the in_right flag of the same sample.
- R3: The attenuation in dB is the channel level plus the master level, each a 7-bit unsigned input, limited to 64. The channel level is lvl_left when in_right is 0 or mono_mode is 1, and lvl_right otherwise.
- R4: For an attenuation n below 64, the gain is G(n) = B[n mod 6] >> (n div 6), with B = {32768, 29205, 26029, 23198, 20675, 18427}, where 32768 means unity. The output is sample*G(n)/32768 truncated toward zero, so at 0 dB the output equals the input.
- R5: At an attenuation of 64 dB the output sample is exactly 0.
- R6: While the captured mute bit is 1, every output sample is exactly 0, and out_vld keeps the timing of R2.
- R7: With mono_mode at 1, every sample uses lvl_left plus lvl_master, whatever its in_right flag.
- R8: A strobe with in_right at 0, or any strobe in mono mode, starts a frame. It captures the live level and mute inputs and uses them at once. A stereo right-channel strobe ignores the live inputs and uses the settings captured at the last frame start.
- R9: An output sample never exceeds its input in magnitude, never has the opposite sign, and stays within the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mono_mode | input | 1 | 1: one channel, always scaled with the left setting |
| lvl_left | input | 7 | Left-channel attenuation in dB |
| lvl_right | input | 7 | Right-channel attenuation in dB |
| lvl_master | input | 7 | Master attenuation in dB, added to the channel level |
| mute_all | input | 1 | Master mute, 1 silences both channels |
| in_vld | input | 1 | Input sample strobe |
| in_right | input | 1 | Channel of the input sample: 0 left, 1 right |
| in_data | input | 16 | Signed input sample |
| out_vld | output | 1 | Output sample strobe |
| out_right | output | 1 | Channel of the output sample |
| out_data | output | 16 | Signed attenuated sample |

## Verification
On every cycle the assertions check the two-cycle strobe and channel-flag delay, zero output under mute and at the 64 dB floor, exact pass-through at 0 dB, and the magnitude and sign limits of the scaled result. Which setting a sample was scaled with is left to the bench's scenarios. This covers the sum and clamp of channel and master levels, left-setting use in mono mode, right samples that ignore a setting change made during their own strobe, and the exact value of every step of the gain law. The bench's model checks these on every clock across sweeps of attenuation and sample value.

// File: rtl/lvl_pkg.sv
// Shared types and gain law of the stereo level stage.
// Assumes a Q1.15 gain format: 32768 is unity.
package lvl_pkg;

    localparam int LVL_W      = 7;   // width of each dB level input
    localparam int DB_PER_OCT = 6;   // dB steps per one-bit shift of gain

    typedef struct packed {
        logic [LVL_W-1:0] left;
        logic [LVL_W-1:0] right;
        logic [LVL_W-1:0] master;
        logic             mute;
    } lvl_set_t;

    // Gain of the first six 1 dB steps, Q1.15.
    function automatic int unsigned db_base(input int unsigned k);
        case (k)
            0:       return 32768;
            1:       return 29205;
            2:       return 26029;
            3:       return 23198;
            4:       return 20675;
            5:       return 18427;
            default: return 0;
        endcase
    endfunction

    // Gain for n dB: base step shifted by whole octaves, zero at the floor.
    function automatic int unsigned gain_calc(input int unsigned n, input int unsigned amax);
        if (n >= amax) return 0;
        return db_base(n % DB_PER_OCT) >> (n / DB_PER_OCT);
    endfunction

endpackage

// File: rtl/lvl_select.sv
// Frame-aligned setting capture and attenuation sum.
// Captures the live settings on a frame-start strobe and uses them in that
// same cycle. Stereo right samples use the captured copy. Output is
// combinational: the clamped attenuation and mute that apply to the current
// strobe.
module lvl_select
    import lvl_pkg::*;
#(
    parameter  int ATT_MAX = 64,
    localparam int ATT_W   = $clog2(ATT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic             in_right,
    input  logic             mono,
    input  lvl_set_t         live,
    output logic [ATT_W-1:0] att,
    output logic             mute
);

    logic             frame_start;
    logic             use_left;
    lvl_set_t         held_q;
    lvl_set_t         use_set;
    logic [LVL_W-1:0] ch_lvl;
    logic [LVL_W:0]   sum;

    // Decide whether this strobe opens a frame and which channel level applies.
    always_comb begin
        use_left    = mono || !in_right;
        frame_start = in_vld && use_left;
    end

    // Hold the settings seen at the last frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (frame_start) begin
            held_q <= live;
        end
    end

    // Pick the settings, add channel and master, clamp at the floor.
    always_comb begin
        use_set = frame_start ? live : held_q;
        ch_lvl  = use_left ? use_set.left : use_set.right;
        sum     = {1'b0, ch_lvl} + {1'b0, use_set.master};
        if (sum >= (LVL_W + 1)'(ATT_MAX)) begin
            att = ATT_W'(ATT_MAX);
        end else begin
            att = ATT_W'(sum);
        end
        mute = use_set.mute;
    end

endmodule

// File: rtl/lvl_gain_rom.sv
// Attenuation-to-gain lookup of ATT_MAX+1 entries.
// The entries are computed at elaboration from the octave-shift law in
// lvl_pkg. The entry at ATT_MAX is zero.
module lvl_gain_rom
    import lvl_pkg::*;
#(
    parameter  int ATT_MAX = 64,
    parameter  int GAIN_W  = 16,
    localparam int ATT_W   = $clog2(ATT_MAX + 1)
) (
    input  logic [ATT_W-1:0]  att,
    output logic [GAIN_W-1:0] gain
);

    logic [GAIN_W-1:0] rom [ATT_MAX+1];

    // One constant entry per dB step.
    for (genvar i = 0; i <= ATT_MAX; i++) begin : g_ent
        assign rom[i] = GAIN_W'(gain_calc(i, ATT_MAX));
    end

    // Read the table; out-of-range indexes give zero gain.
    always_comb begin
        if (int'(att) > ATT_MAX) begin
            gain = '0;
        end else begin
            gain = rom[att];
        end
    end

endmodule

// File: rtl/lvl_scale.sv
// Two-stage scaling pipeline.
// Stage 1 registers the sample with its attenuation and mute. Stage 2 looks
// up the gain, multiplies, truncates toward zero, saturates and forces zero
// for mute or the floor. Assumes att is already clamped to ATT_MAX.
module lvl_scale #(
    parameter  int DATA_W    = 16,
    parameter  int GAIN_W    = 16,
    parameter  int GAIN_FRAC = 15,
    parameter  int ATT_MAX   = 64,
    localparam int ATT_W     = $clog2(ATT_MAX + 1),
    localparam int PROD_W    = DATA_W + GAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic                     in_right,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic [ATT_W-1:0]         att,
    input  logic                     mute,
    output logic                     out_vld,
    output logic                     out_right,
    output logic signed [DATA_W-1:0] out_data
);

    localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((2 ** (DATA_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] MINV = -PROD_W'(2 ** (DATA_W - 1));
    localparam logic signed [PROD_W-1:0] BIAS = PROD_W'((2 ** GAIN_FRAC) - 1);

    logic                     s1_vld;
    logic                     s1_right;
    logic signed [DATA_W-1:0] s1_data;
    logic [ATT_W-1:0]         s1_att;
    logic                     s1_mute;
    logic [GAIN_W-1:0]        gain;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] scaled;
    logic signed [DATA_W-1:0] res;
    logic                     zero_out;

    // Stage 1: capture sample and its settings on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_right <= 1'b0;
            s1_data  <= '0;
            s1_att   <= '0;
            s1_mute  <= 1'b0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_right <= in_right;
                s1_data  <= in_data;
                s1_att   <= att;
                s1_mute  <= mute;
            end
        end
    end

    lvl_gain_rom #(
        .ATT_MAX (ATT_MAX),
        .GAIN_W  (GAIN_W)
    ) u_rom (
        .att  (s1_att),
        .gain (gain)
    );

    // Multiply, truncate toward zero, saturate.
    always_comb begin
        prod   = $signed(s1_data) * $signed({1'b0, gain});
        biased = prod[PROD_W-1] ? prod + BIAS : prod;
        scaled = biased >>> GAIN_FRAC;
        if (scaled > MAXV) begin
            res = DATA_W'(MAXV);
        end else if (scaled < MINV) begin
            res = DATA_W'(MINV);
        end else begin
            res = DATA_W'(scaled);
        end
        zero_out = s1_mute || (int'(s1_att) >= ATT_MAX);
    end

    // Stage 2: register the scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_right <= 1'b0;
            out_data  <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld) begin
                out_right <= s1_right;
                out_data  <= zero_out ? '0 : res;
            end
        end
    end

    // Magnitudes for the range checks below.
    logic signed [DATA_W:0] ext_s1;
    logic signed [DATA_W:0] ext_out;
    logic [DATA_W:0]        mag_s1;
    logic [DATA_W:0]        mag_out;
    always_comb begin
        ext_s1  = {s1_data[DATA_W-1], s1_data};
        ext_out = {out_data[DATA_W-1], out_data};
        mag_s1  = ext_s1[DATA_W] ? -ext_s1 : ext_s1;
        mag_out = ext_out[DATA_W] ? -ext_out : ext_out;
    end

    a_r6_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_mute) |=> (out_data == '0));

    a_r5_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && int'(s1_att) >= ATT_MAX) |=> (out_data == '0));

    a_r4_unity_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_mute && s1_att == '0) |=> (out_data == $past(s1_data)));

    a_r9_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> (mag_out <= $past(mag_s1)));

    a_r9_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_data[DATA_W-1]) |=> !out_data[DATA_W-1]);

    a_r9_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_data[DATA_W-1]) |=> (out_data[DATA_W-1] || out_data == '0));

endmodule

// File: rtl/stereo_level_ctl.sv
// Stereo digital volume and master mute.
// Strobed signed samples pass through frame-aligned setting capture and a
// two-stage scaling pipeline. Latency is two cycles from strobe to strobe.
module stereo_level_ctl
    import lvl_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int GAIN_W    = 16,
    parameter  int GAIN_FRAC = 15,
    parameter  int ATT_MAX   = 64,
    localparam int ATT_W     = $clog2(ATT_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mono_mode,
    input  logic [LVL_W-1:0]         lvl_left,
    input  logic [LVL_W-1:0]         lvl_right,
    input  logic [LVL_W-1:0]         lvl_master,
    input  logic                     mute_all,
    input  logic                     in_vld,
    input  logic                     in_right,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_vld,
    output logic                     out_right,
    output logic signed [DATA_W-1:0] out_data
);

    lvl_set_t         live;
    logic [ATT_W-1:0] att;
    logic             mute;

    // Gather the live control inputs into one record.
    always_comb begin
        live.left   = lvl_left;
        live.right  = lvl_right;
        live.master = lvl_master;
        live.mute   = mute_all;
    end

    lvl_select #(
        .ATT_MAX (ATT_MAX)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_right (in_right),
        .mono     (mono_mode),
        .live     (live),
        .att      (att),
        .mute     (mute)
    );

    lvl_scale #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .ATT_MAX   (ATT_MAX)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_right  (in_right),
        .in_data   (in_data),
        .att       (att),
        .mute      (mute),
        .out_vld   (out_vld),
        .out_right (out_right),
        .out_data  (out_data)
    );

    a_r2_latency_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> ##1 out_vld);

    a_r2_latency_back: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld, 2));

    a_r2_flag_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_right == $past(in_right, 2)));

endmodule

// File: tb/stereo_level_ctl_bench.sv
`timescale 1ns/1ps
module stereo_level_ctl_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mono_mode = 1'b0;
    logic [6:0]        lvl_left = '0;
    logic [6:0]        lvl_right = '0;
    logic [6:0]        lvl_master = '0;
    logic              mute_all = 1'b0;
    logic              in_vld = 1'b0;
    logic              in_right = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              out_vld;
    logic              out_right;
    logic signed [15:0] out_data;

    always #5 clk = ~clk;

    stereo_level_ctl u_stereo_level_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mono_mode  (mono_mode),
        .lvl_left   (lvl_left),
        .lvl_right  (lvl_right),
        .lvl_master (lvl_master),
        .mute_all   (mute_all),
        .in_vld     (in_vld),
        .in_right   (in_right),
        .in_data    (in_data),
        .out_vld    (out_vld),
        .out_right  (out_right),
        .out_data   (out_data)
    );

    int n_checks = 0;
    int n_err    = 0;
    int base [6] = '{32768, 29205, 26029, 23198, 20675, 18427};

    task automatic fail(string tag, string what, int act, int exp);
        n_err++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    // Expected sample from the requirements (R4, R5, R6, R9).
    function automatic int model_out(int s, int att, bit mu);
        int g;
        int r;
        if (mu || att >= 64) return 0;
        g = base[att % 6] >> (att / 6);
        r = (s * g) / 32768;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Reference model state: captured settings and two pipeline slots.
    int    sh_l = 0, sh_r = 0, sh_m = 0;
    bit    sh_mu = 0;
    bit    e1_v = 0, e2_v = 0;
    bit    e1_r = 0, e2_r = 0;
    int    e1_d = 0, e2_d = 0, e1_in = 0, e2_in = 0;
    string e1_tag = "R4", e2_tag = "R4";
    int    neg_cnt = 0;

    // Compare on every clock, then advance the model.
    always @(negedge clk) begin
        int  chl, sum, att, a_out, a_in;
        bit  fs;
        neg_cnt++;
        if (neg_cnt > 2) begin
            n_checks++;
            if (out_vld !== e2_v) fail("R2", "out_vld", int'(out_vld), int'(e2_v));
            if (e2_v) begin
                n_checks++;
                if (out_right !== e2_r) fail("R2", "out_right", int'(out_right), int'(e2_r));
                n_checks++;
                if (int'(out_data) != e2_d) fail(e2_tag, "out_data", int'(out_data), e2_d);
                a_out = (out_data < 0) ? -int'(out_data) : int'(out_data);
                a_in  = (e2_in < 0) ? -e2_in : e2_in;
                n_checks++;
                if (a_out > a_in) fail("R9", "magnitude", a_out, a_in);
            end
        end
        e2_v = e1_v; e2_r = e1_r; e2_d = e1_d; e2_in = e1_in; e2_tag = e1_tag;
        if (!rst_n) begin
            e1_v = 0;
            sh_l = 0; sh_r = 0; sh_m = 0; sh_mu = 0;
        end else if (in_vld) begin
            fs = mono_mode || !in_right;
            if (fs) begin
                sh_l = lvl_left; sh_r = lvl_right; sh_m = lvl_master; sh_mu = mute_all;
            end
            chl = fs ? sh_l : sh_r;
            sum = chl + sh_m;
            att = (sum > 64) ? 64 : sum;
            e1_v  = 1;
            e1_r  = in_right;
            e1_in = int'(in_data);
            e1_d  = model_out(int'(in_data), att, sh_mu);
            if (sh_mu)                           e1_tag = "R6";
            else if (sum > 64)                   e1_tag = "R3";
            else if (att == 64)                  e1_tag = "R5";
            else if (mono_mode && in_right)      e1_tag = "R7";
            else if (!fs)                        e1_tag = "R8";
            else if (chl != 0 && sh_m != 0)      e1_tag = "R3";
            else                                 e1_tag = "R4";
        end else begin
            e1_v = 0;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic put(bit r, int d);
        tick();
        in_vld = 1'b1; in_right = r; in_data = 16'(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            in_vld = 1'b0;
        end
    endtask

    task automatic lv(int l, int r, int m, bit mu);
        lvl_left = 7'(l); lvl_right = 7'(r); lvl_master = 7'(m); mute_all = mu;
    endtask

    logic [31:0] lcg = 32'h1234_5678;
    function automatic int next_sample();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'($signed(lcg[30:15]));
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        fail("R2", "watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        // R1: reset state, with a strobe present during reset.
        lv(9, 9, 9, 1'b1);
        in_vld = 1'b1; in_data = 16'sd1234;
        repeat (3) tick();
        n_checks++;
        if (out_vld !== 1'b0 || out_data !== 16'sd0)
            fail("R1", "reset outputs", int'(out_vld) + int'(out_data), 0);
        in_vld = 1'b0;
        lv(0, 0, 0, 1'b0);
        tick();
        rst_n = 1'b1;
        // R8 with R1: first sample is a right one, so it uses the reset settings (0 dB).
        lv(20, 20, 20, 1'b1);
        put(1, 12345);
        idle(3);

        // R4: unity gain with extreme and ordinary values.
        lv(0, 0, 0, 1'b0);
        put(0, 1000); put(1, -1000); put(0, 32767); put(1, -32768);
        put(0, 0); put(1, 1);
        idle(2);

        // R3: channel plus master; back-to-back and gapped strobes.
        lv(3, 10, 2, 1'b0);
        put(0, 20000); put(1, 20000); idle(1);
        put(0, -20001); idle(2); put(1, -7); put(0, 32767); put(1, -32768);
        idle(2);

        // R3, R5: clamp at the floor, just above it, and at it.
        lv(40, 63, 30, 1'b0);
        put(0, 30000); put(1, 30000);
        lv(127, 1, 0, 1'b0);
        put(0, -30000); put(1, -30000);
        lv(64, 0, 0, 1'b0);
        put(0, 32767); put(1, 32767);
        idle(2);

        // R6: mute toggled on and off mid-stream.
        lv(0, 0, 0, 1'b1);
        put(0, 5000); put(1, -5000); put(0, 32767); put(1, -32768);
        lv(0, 0, 0, 1'b0);
        put(0, 5000); put(1, -5000);
        idle(2);

        // R7: mono mode uses the left level even for right-flagged samples.
        mono_mode = 1'b1;
        lv(5, 30, 1, 1'b0);
        put(1, 16000); put(1, -16000); put(0, 9999);
        lv(5, 30, 1, 1'b1);
        put(1, 16000);
        mono_mode = 1'b0;
        lv(0, 0, 0, 1'b0);
        idle(2);

        // R8: a setting change during a right strobe waits for the next frame.
        lv(6, 6, 0, 1'b0);
        put(0, 24000);
        put(1, 24000); lv(30, 30, 10, 1'b1);
        put(0, 24000); put(1, 24000);
        lv(0, 0, 0, 1'b0);
        put(1, 24000);
        put(0, 24000); put(1, 24000);
        idle(2);

        // R4, R9: sweep every attenuation step with varied samples on both channels.
        for (int a = 0; a <= 66; a++) begin
            lv(a, a / 2, a - a / 2, 1'b0);
            put(0, next_sample());
            put(1, next_sample());
            put(0, -32768);
            put(1, 32767);
        end
        idle(4);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule